// File: doc/BRIEF.md
# Write-Through Store Buffer with Read-First Memory Arbitration

This unit sits between a write-through cache and main memory. Each processor store is written into a small in-order queue of address/data pairs. The queue empties into memory in the background, so stores leave no dirty lines in the cache and do not hold up the processor unless the queue is full. Read misses come from instruction fetch or data loads. They stall the processor, so the unit gives them the single memory port ahead of any queued store that has not yet started.

A read whose address is still held in the queue is answered straight from the queue with the youngest matching data. It makes no memory access, so it can never see a stale memory word. All other reads go to memory through a request/grant/done handshake. Only one memory transaction is outstanding at a time, and a transaction that has started is never cut short.

Top module: `wtb_top`

## Requirements
- R1: After reset `mem_req` is 0, `rd_done` is 0 and `st_stall` is 0, and the queue is empty.
- R2: Each store accepted (`st_valid` high while `st_stall` is low at a rising edge) produces exactly one memory write (`mem_we`=1) with its address and data. The writes reach memory in the order the stores were accepted.
- R3: The queue holds `DEPTH` entries, and an entry stays counted until its memory write completes. `st_stall` is high while `DEPTH` entries are held. A store presented while `st_stall` is high is not accepted and never reaches memory.
- R4: When the port is idle and a read needing memory is pending, the read is issued (`mem_we`=0) before any queued write that has not started. `rd_data` carries `mem_rdata` and `rd_done` rises one cycle after the `mem_done` of that read.
- R5: A read whose address matches a queued entry gets `rd_done` on the first rising edge after it is presented, with the data of the youngest matching entry. It causes no memory read.
- R6: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay steady until `mem_gnt`. `mem_req` is low in the cycle after the grant, and no new request appears before `mem_done` of the current one.
- R7: A memory write already requested is completed even when a read arrives. The read is issued in the next idle slot, ahead of the remaining queued writes.
- R8: `rd_done` is a single-cycle pulse. The requester holds `rd_valid` and `rd_addr` until it sees `rd_done` and drops `rd_valid` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_stall | output | 1 | Queue full, store not taken |
| rd_valid | input | 1 | Read-miss request, held until rd_done |
| rd_addr | input | AW | Read word address |
| rd_done | output | 1 | Read result valid (one cycle) |
| rd_data | output | DW | Read result |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Memory accepted the request |
| mem_done | input | 1 | Memory finished; read data valid |
| mem_rdata | input | DW | Memory read data |

## Verification
The checker watches every cycle for a steady request command until grant, for the request dropping after grant, and for a write never being issued while a memory-bound read waits. It also watches for `rd_done` being a single pulse, for queue hits answering on the next edge, and for the occupancy bound. Only the bench's scenarios can show the end-to-end results. These are that memory receives writes in acceptance order and ends with the reference contents. They also include that reads return the youngest queued value, and that a read overtakes queued writes but not a write in flight. The last is that a store refused while the queue is full never reaches memory.

// File: rtl/wtb_pkg.sv
package wtb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_REQ  = 2'd1,
    ARB_WAIT = 2'd2
  } arb_state_t;
endpackage

// File: rtl/wtb_queue.sv
module wtb_queue #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [AW-1:0]   push_addr,
  input  logic [DW-1:0]   push_data,
  input  logic            pop,
  input  logic [AW-1:0]   look_addr,
  output logic [AW-1:0]   head_addr,
  output logic [DW-1:0]   head_data,
  output logic            empty,
  output logic            full,
  output logic [CNTW-1:0] count,
  output logic            fwd_hit,
  output logic [DW-1:0]   fwd_data
);
  // DEPTH must be a power of two so the pointers wrap by overflow.
  logic [AW-1:0]   q_addr [DEPTH];
  logic [DW-1:0]   q_data [DEPTH];
  logic [PTRW-1:0] wr_ptr, rd_ptr;

  assign empty = (count == '0);
  assign full  = (count == CNTW'(DEPTH));
  assign head_addr = q_addr[rd_ptr];
  assign head_data = q_data[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wr_ptr] <= push_addr;
      q_data[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  // Scan from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PTRW-1:0] idx;
      idx = rd_ptr + PTRW'(i);
      if ((CNTW'(i) < count) && (q_addr[idx] == look_addr)) begin
        fwd_hit  = 1'b1;
        fwd_data = q_data[idx];
      end
    end
  end
endmodule

// File: rtl/wtb_arb.sv
module wtb_arb
  import wtb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_avail,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_gnt,
  input  logic          mem_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rd_busy,
  output logic          rd_fill,
  output logic          wr_pop
);
  arb_state_t state;
  logic       is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ARB_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      is_rd     <= 1'b0;
    end else begin
      unique case (state)
        ARB_IDLE: begin
          if (rd_go) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= rd_addr;
            is_rd    <= 1'b1;
            state    <= ARB_REQ;
          end else if (wr_avail) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= head_addr;
            mem_wdata <= head_data;
            is_rd     <= 1'b0;
            state     <= ARB_REQ;
          end
        end
        ARB_REQ: begin
          if (mem_gnt) begin
            mem_req <= 1'b0;
            state   <= ARB_WAIT;
          end
        end
        ARB_WAIT: begin
          if (mem_done) state <= ARB_IDLE;
        end
        default: state <= ARB_IDLE;
      endcase
    end
  end

  assign rd_busy = is_rd && (state != ARB_IDLE);
  assign rd_fill = (state == ARB_WAIT) && mem_done && is_rd;
  assign wr_pop  = (state == ARB_WAIT) && mem_done && !is_rd;
endmodule

// File: rtl/wtb_top.sv
module wtb_top #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_stall,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_done,
  input  logic [DW-1:0] mem_rdata
);
  logic            q_full, q_empty, fwd_hit, wr_pop, rd_busy, rd_fill;
  logic [AW-1:0]   head_addr;
  logic [DW-1:0]   head_data, fwd_data;
  logic [CNTW-1:0] q_count;
  logic            rd_pend, rd_fwd, rd_go, push;

  assign st_stall = q_full;
  assign push     = st_valid && !q_full;
  assign rd_pend  = rd_valid && !rd_done && !rd_busy;
  assign rd_fwd   = rd_pend && fwd_hit;
  assign rd_go    = rd_pend && !fwd_hit;

  wtb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .push(push), .push_addr(st_addr), .push_data(st_data),
    .pop(wr_pop), .look_addr(rd_addr),
    .head_addr(head_addr), .head_data(head_data),
    .empty(q_empty), .full(q_full), .count(q_count),
    .fwd_hit(fwd_hit), .fwd_data(fwd_data)
  );

  wtb_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst(rst),
    .rd_go(rd_go), .rd_addr(rd_addr),
    .wr_avail(!q_empty), .head_addr(head_addr), .head_data(head_data),
    .mem_gnt(mem_gnt), .mem_done(mem_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rd_busy(rd_busy), .rd_fill(rd_fill), .wr_pop(wr_pop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_done <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_done <= rd_fwd || rd_fill;
      if (rd_fwd)       rd_data <= fwd_data;
      else if (rd_fill) rd_data <= mem_rdata;
    end
  end
endmodule

// File: rtl/wtb_chk.sv
module wtb_chk #(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_req,
  input logic            mem_gnt,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic            rd_valid,
  input logic            rd_done,
  input logic            rd_busy,
  input logic            fwd_hit,
  input logic [CNTW-1:0] q_count
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R6
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_gnt |=> !mem_req); // R6
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) && mem_we |-> !$past(rd_valid && !rd_done && !rd_busy && !fwd_hit)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done); // R8
  AST_FWD_NEXT: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_done && !rd_busy && fwd_hit |=> rd_done); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNTW'(DEPTH)); // R3
endmodule

bind wtb_top wtb_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
  .mem_addr(mem_addr), .rd_valid(rd_valid), .rd_done(rd_done), .rd_busy(rd_busy),
  .fwd_hit(fwd_hit), .q_count(q_count)
);

// File: tb/sim_wtb_top.sv
`timescale 1ns/1ps
module sim_wtb_top;
  localparam int AW = 8, DW = 16, DEPTH = 4, NW = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic st_valid = 0, rd_valid = 0, st_stall, rd_done, mem_req, mem_we;
  logic [AW-1:0] st_addr = '0, rd_addr = '0, mem_addr;
  logic [DW-1:0] st_data = '0, rd_data, mem_wdata;
  logic mem_gnt = 0, mem_done = 0;
  logic [DW-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  wtb_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (.*);

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model with transaction log
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] refm [NW];
  logic          log_we [64];
  logic [AW-1:0] log_a [64];
  int log_n = 0, rd_log_n = 0, proto_err = 0;
  bit hold = 0;
  int phase = 0, lat = 0;
  logic          c_we;
  logic [AW-1:0] c_a;
  logic [DW-1:0] c_d;

  initial for (int i = 0; i < NW; i++) begin
    mem[i] = DW'(16'h1000 + i);
    refm[i] = DW'(16'h1000 + i);
  end

  always @(posedge clk) begin
    case (phase)
      0: if (!rst && mem_req && !hold) begin
           mem_gnt <= 1; c_we = mem_we; c_a = mem_addr; c_d = mem_wdata; phase = 1;
         end
      1: begin
           if (!mem_req || mem_addr != c_a || mem_we != c_we) proto_err++;
           mem_gnt <= 0; lat = 2; phase = 2;
         end
      2: begin
           if (mem_req) proto_err++;
           if (lat == 0) begin
             mem_done <= 1;
             if (c_we) mem[c_a] = c_d; else begin mem_rdata <= mem[c_a]; rd_log_n++; end
             if (log_n < 64) begin log_we[log_n] = c_we; log_a[log_n] = c_a; end
             log_n++;
             phase = 3;
           end else lat--;
         end
      default: begin
           if (mem_req) proto_err++;
           mem_done <= 0; phase = 0;
         end
    endcase
  end

  // expected write order
  logic [AW-1:0] exp_a [64];
  int exp_n = 0;

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d;
    while (st_stall) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    st_valid = 0;
    refm[a] = d; exp_a[exp_n] = a; exp_n++;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int cyc);
    @(negedge clk);
    rd_valid = 1; rd_addr = a; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!rd_done && cyc < 300);
    d = rd_data; rd_valid = 0;
    @(negedge clk);
    chk(rd_done == 0, "R8 done pulse", rd_done, 0);
  endtask

  // vector table: {is_read, addr, data (store data or expected read data)}
  localparam logic [24:0] VEC [6] = '{
    25'h0_03_0033, 25'h0_05_0055, 25'h0_03_0333,
    25'h1_03_0333, 25'h1_07_1007, 25'h1_05_0055
  };

  int cyc_cnt = 0;
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int cyc, n0, r0, wi, mis;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_req == 0, "R1 mem_req", mem_req, 0);
    chk(rd_done == 0, "R1 rd_done", rd_done, 0);
    chk(st_stall == 0, "R1 st_stall", st_stall, 0);
    rst = 0;

    // table walk: R2 ordering and R5/R4 read values
    foreach (VEC[k]) begin
      if (VEC[k][24]) begin
        do_read(VEC[k][23:16], d, cyc);
        chk(d == VEC[k][15:0], "R5 R4 table read", d, VEC[k][15:0]);
      end else do_store(VEC[k][23:16], VEC[k][15:0]);
    end
    repeat (40) @(negedge clk);

    // R3: fill the queue while memory withholds grant
    hold = 1;
    for (int i = 0; i < DEPTH; i++) do_store(AW'(8'h40 + i), DW'(16'h4400 + i));
    chk(st_stall == 1, "R3 stall when full", st_stall, 1);
    @(negedge clk);
    st_valid = 1; st_addr = 8'h50; st_data = 16'hDEAD;
    repeat (3) @(negedge clk);
    st_valid = 0;
    hold = 0;
    repeat (60) @(negedge clk);
    chk(mem[8'h50] == 16'h1050, "R3 refused store", mem[8'h50], 16'h1050);

    // R4/R7: write in flight completes, read then overtakes the queued write
    hold = 1;
    n0 = log_n;
    do_store(8'h10, 16'h0A10);
    do_store(8'h11, 16'h0A11);
    fork
      do_read(8'h20, d, cyc);
      begin repeat (5) @(negedge clk); hold = 0; end
    join
    chk(d == 16'h1020, "R4 read data", d, 16'h1020);
    repeat (40) @(negedge clk);
    chk(log_we[n0] == 1 && log_a[n0] == 8'h10, "R7 write in flight first", log_a[n0], 8'h10);
    chk(log_we[n0+1] == 0 && log_a[n0+1] == 8'h20, "R4 read before queued write", log_a[n0+1], 8'h20);
    chk(log_we[n0+2] == 1 && log_a[n0+2] == 8'h11, "R4 queued write after read", log_a[n0+2], 8'h11);

    // R5: forwarded read, one cycle, no memory read
    hold = 1;
    do_store(8'h60, 16'hBEEF);
    do_store(8'h60, 16'hCAFE);
    r0 = rd_log_n;
    do_read(8'h60, d, cyc);
    chk(d == 16'hCAFE, "R5 youngest data", d, 16'hCAFE);
    chk(cyc == 1, "R5 latency", cyc, 1);
    hold = 0;
    repeat (60) @(negedge clk);
    chk(rd_log_n == r0, "R5 no memory read", rd_log_n, r0);

    // R2: write order and final contents; R6 handshake
    wi = 0; mis = 0;
    for (int i = 0; i < log_n && i < 64; i++)
      if (log_we[i]) begin
        if (wi >= exp_n || log_a[i] != exp_a[wi]) mis++;
        wi++;
      end
    chk(mis == 0 && wi == exp_n, "R2 write order", wi, exp_n);
    mis = 0;
    for (int i = 0; i < NW; i++) if (mem[i] != refm[i]) mis++;
    chk(mis == 0, "R2 final memory", mis, 0);
    chk(proto_err == 0, "R6 handshake", proto_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule